// File: doc/BRIEF.md
# Bus Master Attribute Assigner

This block stamps every transaction leaving a bus-master peripheral (a DMA engine, a storage controller and the like) with three security attributes: a compartment identifier (CID), a secure bit and a privilege bit. Each master has one configuration entry. The entry picks where the CID comes from. It is either inherited from the protection slot of the peripheral that owns the master, or taken from a value held in the entry. Inheritance is the default after reset.

The secure and privilege bits always come from the entry, whichever CID source is chosen. Masters built with the guard option can never issue secure traffic while their owning peripheral slot is nonsecure. Only the trusted-domain CID may change an entry. Any other write is dropped and reported on a one-cycle flag. The attribute path is combinational from the registered entries and the live slot attributes. A write therefore applies to every transaction presented from the cycle after the write edge.

Top module: `mattr_assigner`

## Requirements
- R1: After reset every entry is nonsecure, unprivileged, in inherit mode (select bit 0) with stored CID 0.
- R2: In inherit mode, when the owning slot has CID filtering enabled, `txn_cid` equals that slot's CID.
- R3: In inherit mode, when the owning slot has CID filtering disabled, `txn_cid` is 0.
- R4: In explicit mode (select bit 1), `txn_cid` equals the entry's stored CID regardless of the slot's CID or filter setting.
- R5: `txn_priv` equals the entry's privilege bit and `txn_sec` equals its secure bit (subject to R6) in both CID modes.
- R6: For a master whose bit in `GUARD_MASK` is 1, `txn_sec` is 0 whenever its slot's secure input is 0. Masters with a 0 mask bit are not affected by the slot secure input.
- R7: A write whose `cfg_src_cid` differs from `TRUSTED_CID` changes no entry, and `cfg_denied` is 1 for exactly the cycle after it.
- R8: A write from the trusted CID to an index of `N_MASTERS` or above changes no entry, and `cfg_denied` is 1 for the cycle after it.
- R9: An accepted write is reflected on the transaction outputs in the first cycle after the clock edge that captured it.
- R10: `txn_out_valid` follows `txn_valid`. For a `txn_midx` of `N_MASTERS` or above, `txn_cid`, `txn_sec` and `txn_priv` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_src_cid | input | CID_W | CID of the agent issuing the write |
| cfg_idx | input | IDX_W | Master entry addressed by the write |
| cfg_sec | input | 1 | Secure bit to store |
| cfg_priv | input | 1 | Privilege bit to store |
| cfg_explicit | input | 1 | CID source select to store: 1 explicit, 0 inherit |
| cfg_cid | input | CID_W | Explicit CID to store |
| cfg_denied | output | 1 | Registered flag: the previous cycle's write was rejected |
| slot_sec | input | N_MASTERS | Secure attribute of each master's owning slot |
| slot_cfen | input | N_MASTERS | CID filtering enable of each owning slot |
| slot_cid | input | N_MASTERS*CID_W | CID of each owning slot, master 0 in the low bits |
| txn_valid | input | 1 | A transaction is being issued |
| txn_midx | input | IDX_W | Index of the issuing master |
| txn_out_valid | output | 1 | Stamped transaction valid |
| txn_cid | output | CID_W | CID attached to the transaction |
| txn_sec | output | 1 | Secure attribute attached to the transaction |
| txn_priv | output | 1 | Privilege attribute attached to the transaction |

## Verification
The hardest case to reach is a guarded master programmed as secure while its slot flips between secure and nonsecure. The programmed bit and the emitted bit then disagree without any write taking place. The stimulus first loads a secure entry from the trusted CID and then toggles only `slot_sec` under that master and under an unguarded neighbour. A long random phase follows that mixes trusted, untrusted and out-of-range writes with random slot attributes. A behavioural model tracks every entry and the denied flag, and the outputs are compared against it on every cycle.

// File: rtl/mattr_pkg.sv
// Package: shared widths and the per-master configuration entry type.
// Assumes every block in the assigner uses the same CID width.
package mattr_pkg;
    localparam int CID_W = 3;

    typedef struct packed {
        logic             sec;
        logic             priv;
        logic             explicit_sel;
        logic [CID_W-1:0] cid;
    } mattr_entry_t;

    localparam int ENTRY_W = $bits(mattr_entry_t);
endpackage

// File: rtl/mattr_cfg_bank.sv
// Configuration bank: one entry per master, written only by the trusted CID
// to an in-range index. A rejected write raises wr_denied for one cycle.
// Assumes a synchronous active-low reset and a single write port.
module mattr_cfg_bank
    import mattr_pkg::*;
#(
    parameter int N_MASTERS   = 5,
    parameter int IDX_W       = 3,
    parameter int TRUSTED_CID = 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [CID_W-1:0]             wr_cid,
    input  logic [IDX_W-1:0]             wr_idx,
    input  mattr_entry_t                 wr_val,
    output logic [N_MASTERS*ENTRY_W-1:0] bank_flat,
    output logic                         wr_denied
);
    localparam logic [CID_W-1:0] TRUST_V = CID_W'(TRUSTED_CID);
    localparam logic [IDX_W:0]   N_EXT   = (IDX_W+1)'(N_MASTERS);

    logic wr_trusted;
    logic wr_inrange;
    logic wr_accept;

    // Decode whether the incoming write is allowed to land.
    always_comb begin
        wr_trusted = (wr_cid == TRUST_V);
        wr_inrange = ({1'b0, wr_idx} < N_EXT);
        wr_accept  = wr_en && wr_trusted && wr_inrange;
    end

    for (genvar i = 0; i < N_MASTERS; i++) begin : g_entry
        mattr_entry_t ent_q;
        // Hold entry i; load it on an accepted write addressed to it.
        always_ff @(posedge clk) begin
            if (!rst_n)
                ent_q <= '0;
            else if (wr_accept && (wr_idx == IDX_W'(i)))
                ent_q <= wr_val;
        end
        assign bank_flat[i*ENTRY_W +: ENTRY_W] = ent_q;
    end

    // Flag a rejected write for the following cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wr_denied <= 1'b0;
        else
            wr_denied <= wr_en && !wr_accept;
    end

    assert_untrusted_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_cid != TRUST_V) |=> wr_denied);
    assert_untrusted_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_cid != TRUST_V) |=> $stable(bank_flat));
    assert_oob_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && {1'b0, wr_idx} >= N_EXT) |=> ($stable(bank_flat) && wr_denied));
endmodule

// File: rtl/mattr_resolve.sv
// Resolver for one master: turns its entry and its owning slot's attributes
// into the effective CID, secure and privilege bits. GUARD selects whether a
// nonsecure slot forces the master nonsecure. Clock and reset feed only the
// checks.
module mattr_resolve
    import mattr_pkg::*;
#(
    parameter bit GUARD = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  mattr_entry_t     entry,
    input  logic             s_sec,
    input  logic             s_cfen,
    input  logic [CID_W-1:0] s_cid,
    output logic [CID_W-1:0] eff_cid,
    output logic             eff_sec,
    output logic             eff_priv
);
    logic inh_cid_ok;
    logic guard_block;

    // Pick the CID source and apply the secure guard.
    always_comb begin
        inh_cid_ok  = s_cfen;
        guard_block = GUARD && !s_sec;
        if (entry.explicit_sel)
            eff_cid = entry.cid;
        else if (inh_cid_ok)
            eff_cid = s_cid;
        else
            eff_cid = '0;
        eff_sec  = entry.sec && !guard_block;
        eff_priv = entry.priv;
    end

    assert_guard_forces_ns_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (GUARD && !s_sec) |-> !eff_sec);
    assert_inherit_nofilter_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!entry.explicit_sel && !s_cfen) |-> (eff_cid == '0));
    assert_explicit_cid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        entry.explicit_sel |-> (eff_cid == entry.cid));
endmodule

// File: rtl/mattr_select.sv
// Selector: routes the resolved attributes of the issuing master onto the
// transaction outputs. An index outside the master range yields all zeros.
module mattr_select
    import mattr_pkg::*;
#(
    parameter int N_MASTERS = 5,
    parameter int IDX_W     = 3
) (
    input  logic [N_MASTERS*CID_W-1:0] all_cid,
    input  logic [N_MASTERS-1:0]       all_sec,
    input  logic [N_MASTERS-1:0]       all_priv,
    input  logic [IDX_W-1:0]           sel_idx,
    output logic [CID_W-1:0]           sel_cid,
    output logic                       sel_sec,
    output logic                       sel_priv
);
    // Choose the entry that matches the issuing index.
    always_comb begin
        sel_cid  = '0;
        sel_sec  = 1'b0;
        sel_priv = 1'b0;
        for (int i = 0; i < N_MASTERS; i++) begin
            if (sel_idx == IDX_W'(i)) begin
                sel_cid  = all_cid[i*CID_W +: CID_W];
                sel_sec  = all_sec[i];
                sel_priv = all_priv[i];
            end
        end
    end
endmodule

// File: rtl/mattr_assigner.sv
// Top: bus master attribute assigner. Holds one configuration entry per
// master, resolves each master's attributes against its owning slot, and
// stamps the issuing master's attributes onto the transaction. Slot inputs
// are index-aligned with masters. Synchronous active-low reset.
module mattr_assigner
    import mattr_pkg::*;
#(
    parameter int                   N_MASTERS   = 5,
    parameter int                   IDX_W       = 3,
    parameter int                   TRUSTED_CID = 1,
    parameter logic [N_MASTERS-1:0] GUARD_MASK  = 5'b00101
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_wr,
    input  logic [CID_W-1:0]           cfg_src_cid,
    input  logic [IDX_W-1:0]           cfg_idx,
    input  logic                       cfg_sec,
    input  logic                       cfg_priv,
    input  logic                       cfg_explicit,
    input  logic [CID_W-1:0]           cfg_cid,
    output logic                       cfg_denied,
    input  logic [N_MASTERS-1:0]       slot_sec,
    input  logic [N_MASTERS-1:0]       slot_cfen,
    input  logic [N_MASTERS*CID_W-1:0] slot_cid,
    input  logic                       txn_valid,
    input  logic [IDX_W-1:0]           txn_midx,
    output logic                       txn_out_valid,
    output logic [CID_W-1:0]           txn_cid,
    output logic                       txn_sec,
    output logic                       txn_priv
);
    localparam logic [IDX_W:0] N_EXT = (IDX_W+1)'(N_MASTERS);

    mattr_entry_t                 wr_val;
    logic [N_MASTERS*ENTRY_W-1:0] bank_flat;
    logic [N_MASTERS*CID_W-1:0]   res_cid;
    logic [N_MASTERS-1:0]         res_sec;
    logic [N_MASTERS-1:0]         res_priv;

    // Pack the write fields into an entry.
    always_comb begin
        wr_val.sec          = cfg_sec;
        wr_val.priv         = cfg_priv;
        wr_val.explicit_sel = cfg_explicit;
        wr_val.cid          = cfg_cid;
    end

    mattr_cfg_bank #(
        .N_MASTERS(N_MASTERS), .IDX_W(IDX_W), .TRUSTED_CID(TRUSTED_CID)
    ) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .wr_cid(cfg_src_cid),
        .wr_idx(cfg_idx), .wr_val(wr_val), .bank_flat(bank_flat),
        .wr_denied(cfg_denied)
    );

    for (genvar i = 0; i < N_MASTERS; i++) begin : g_res
        mattr_resolve #(.GUARD(GUARD_MASK[i])) u_res (
            .clk(clk), .rst_n(rst_n),
            .entry(mattr_entry_t'(bank_flat[i*ENTRY_W +: ENTRY_W])),
            .s_sec(slot_sec[i]), .s_cfen(slot_cfen[i]),
            .s_cid(slot_cid[i*CID_W +: CID_W]),
            .eff_cid(res_cid[i*CID_W +: CID_W]),
            .eff_sec(res_sec[i]), .eff_priv(res_priv[i])
        );
    end

    mattr_select #(.N_MASTERS(N_MASTERS), .IDX_W(IDX_W)) u_sel (
        .all_cid(res_cid), .all_sec(res_sec), .all_priv(res_priv),
        .sel_idx(txn_midx), .sel_cid(txn_cid), .sel_sec(txn_sec),
        .sel_priv(txn_priv)
    );

    assign txn_out_valid = txn_valid;

    assert_oob_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, txn_midx} >= N_EXT) |-> (txn_cid == '0 && !txn_sec && !txn_priv));
    assert_valid_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        txn_out_valid == txn_valid);
endmodule

// File: tb/mattr_assigner_tb_top.sv
// Bench: behavioural model of the entries and the denied flag, compared
// against the outputs on every cycle.
module mattr_assigner_tb_top;
    localparam int N = 5;
    localparam int IW = 3;
    localparam int CW = 3;
    localparam int TRUST = 1;
    localparam logic [N-1:0] GMASK = 5'b00101;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_wr = 1'b0, cfg_sec = 1'b0, cfg_priv = 1'b0, cfg_explicit = 1'b0;
    logic [CW-1:0] cfg_src_cid = '0, cfg_cid = '0;
    logic [IW-1:0] cfg_idx = '0, txn_midx = '0;
    logic cfg_denied;
    logic [N-1:0] slot_sec = '0, slot_cfen = '0;
    logic [CW-1:0] s_cid [N];
    logic [N*CW-1:0] slot_cid;
    logic txn_valid = 1'b0;
    logic txn_out_valid, txn_sec, txn_priv;
    logic [CW-1:0] txn_cid;

    int total = 0, bad = 0;
    bit finished = 0;
    string tag = "R1";

    // model state
    bit m_sec [N], m_priv [N], m_exp [N];
    int m_cid [N];
    bit e_denied = 0;
    int last_den_req = 7;

    always #10 clk = ~clk;

    always_comb for (int i = 0; i < N; i++) slot_cid[i*CW +: CW] = s_cid[i];

    mattr_assigner dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_src_cid(cfg_src_cid),
        .cfg_idx(cfg_idx), .cfg_sec(cfg_sec), .cfg_priv(cfg_priv),
        .cfg_explicit(cfg_explicit), .cfg_cid(cfg_cid), .cfg_denied(cfg_denied),
        .slot_sec(slot_sec), .slot_cfen(slot_cfen), .slot_cid(slot_cid),
        .txn_valid(txn_valid), .txn_midx(txn_midx), .txn_out_valid(txn_out_valid),
        .txn_cid(txn_cid), .txn_sec(txn_sec), .txn_priv(txn_priv)
    );

    // model update at the capturing edge
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                m_sec[i] = 0; m_priv[i] = 0; m_exp[i] = 0; m_cid[i] = 0;
            end
            e_denied = 0;
        end else begin
            e_denied = 0;
            if (cfg_wr) begin
                if (int'(cfg_src_cid) != TRUST) begin
                    e_denied = 1; last_den_req = 7;
                end else if (int'(cfg_idx) >= N) begin
                    e_denied = 1; last_den_req = 8;
                end else begin
                    m_sec[cfg_idx] = cfg_sec; m_priv[cfg_idx] = cfg_priv;
                    m_exp[cfg_idx] = cfg_explicit; m_cid[cfg_idx] = int'(cfg_cid);
                end
            end
        end
    end

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s [%s] actual=%0d expected=%0d t=%0t", req, tag, act, exp, $time);
        end
    endtask

    // compare all outputs with the model
    task automatic compare();
        int m = int'(txn_midx);
        int ecid, esec, epriv;
        string rc, rs;
        if (m >= N) begin
            ecid = 0; esec = 0; epriv = 0; rc = "R10"; rs = "R10";
        end else begin
            if (m_exp[m]) begin ecid = m_cid[m]; rc = "R4"; end
            else if (slot_cfen[m]) begin ecid = int'(s_cid[m]); rc = "R2"; end
            else begin ecid = 0; rc = "R3"; end
            esec = (m_sec[m] && !(GMASK[m] && !slot_sec[m])) ? 1 : 0;
            rs = (GMASK[m] && !slot_sec[m]) ? "R6" : "R5";
            epriv = m_priv[m] ? 1 : 0;
        end
        chk(rc, int'(txn_cid), ecid);
        chk(rs, int'(txn_sec), esec);
        chk("R5", int'(txn_priv), epriv);
        chk("R10", int'(txn_out_valid), int'(txn_valid));
        chk(last_den_req == 8 ? "R8" : "R7", int'(cfg_denied), e_denied ? 1 : 0);
    endtask

    // inputs already set after a negedge: settle, compare, then wait for next negedge
    task automatic step();
        #2 compare();
        @(negedge clk);
    endtask

    task automatic wr(int src, int idx, bit s, bit p, bit x, int c);
        cfg_wr = 1; cfg_src_cid = CW'(src); cfg_idx = IW'(idx);
        cfg_sec = s; cfg_priv = p; cfg_explicit = x; cfg_cid = CW'(c);
        step();
        cfg_wr = 0;
    endtask

    task automatic sweep();
        for (int m = 0; m < 8; m++) begin
            txn_valid = 1; txn_midx = IW'(m); step();
        end
    endtask

    initial begin
        for (int i = 0; i < N; i++) s_cid[i] = CW'(i + 2);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1: reset defaults, slots filtering on and secure
        tag = "R1"; slot_cfen = '1; slot_sec = '1; sweep();
        // R2 / R3: inherit with filtering on and off
        tag = "R2"; slot_cfen = 5'b10101; sweep();
        tag = "R3"; slot_cfen = '0; sweep();
        // R4 / R5 / R9: explicit entry visible the cycle after the write
        tag = "R9"; txn_midx = 3'd1;
        wr(TRUST, 1, 1, 1, 1, 5);
        step();
        tag = "R4"; slot_cfen = '1; s_cid[1] = 3'd6; step();
        wr(TRUST, 4, 0, 1, 0, 7); tag = "R5"; txn_midx = 3'd4; step();
        // R6: guarded master 0 secure, toggle its slot secure bit
        tag = "R6"; wr(TRUST, 0, 1, 0, 0, 0);
        txn_midx = 3'd0; slot_sec = 5'b11110; step();
        slot_sec = 5'b11111; step();
        slot_sec = 5'b00000; step();
        txn_midx = 3'd1; step();
        slot_sec = 5'b11111; step();
        // R7: untrusted write ignored and flagged
        tag = "R7"; txn_midx = 3'd3; wr(2, 3, 1, 1, 1, 4); step(); step();
        wr(0, 1, 0, 0, 0, 0); txn_midx = 3'd1; step();
        // R8: out-of-range index from trusted CID
        tag = "R8"; wr(TRUST, 6, 1, 1, 1, 1); step(); sweep();
        // R10: idle and out-of-range issue
        tag = "R10"; txn_valid = 0; txn_midx = 3'd7; step();
        txn_valid = 1; step();
        // random mix
        tag = "rand";
        for (int k = 0; k < 600; k++) begin
            int r = $urandom_range(0, 9);
            slot_sec = N'($urandom); slot_cfen = N'($urandom);
            for (int i = 0; i < N; i++) s_cid[i] = CW'($urandom);
            txn_valid = 1'($urandom); txn_midx = IW'($urandom);
            if (r < 5) wr((r == 0) ? 3 : TRUST, $urandom_range(0, 7),
                          1'($urandom), 1'($urandom), 1'($urandom), $urandom_range(0, 7));
            else step();
        end
        // R1 again: reset clears programmed entries
        tag = "R1"; rst_n = 0; @(negedge clk); @(negedge clk); rst_n = 1;
        slot_sec = '1; slot_cfen = '0; sweep();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 20);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog [%s] actual=running expected=done", tag);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule